// File: doc/BRIEF.md
# Chip-Select Wait-State Bus Sequencer

This block times single external memory accesses against a bus clock. A requester presents an address, a direction and a one-cycle valid pulse. The sequencer works out which area the address falls in: one of four external chip-select windows, a special-function register window, or internal memory. It then holds the chip-select line, when the area has one, and the read or write strobe for the right number of clocks. It gives a one-cycle completion pulse when the access ends.

Each external window has a fast-mode bit and a two-bit stretch field, both written through a small configuration port. Together they set the read length and the write length for that window. A ready input can lengthen slow-mode external accesses one clock at a time. An access that finds its window set to an illegal combination runs with the fast timing and sets a sticky error flag.

Top module: `csw_bus_seq`

## Requirements
- R1: After synchronous reset every fast-mode bit and stretch field is 0, `err_o`, `busy_o`, `cs_o`, `rd_o`, `wr_o` and `done_o` are 0, and an external read or write with ready high lasts 2 clocks.
- R2: Address decode uses the top three address bits: `000` is the register window, `010`/`011` are internal memory, and `1ab` is external window `ab` (0..3). `cs_o` bit `ab` is high during every strobe clock of an access to window `ab`, and `cs_o` stays all zero for the other areas.
- R3: A window whose fast-mode bit is 1 and whose stretch field is `00` runs a read in 1 clock and a write in 2 clocks.
- R4: A window whose fast-mode bit is 0 runs reads and writes with the same length: stretch `00` or `01` gives 2 clocks, `10` gives 3 and `11` gives 4.
- R5: Register-window accesses last 2 clocks and internal-memory accesses last 1 clock, whatever the window settings.
- R6: On a slow-mode external access, `rdy_i` is sampled at the end of the last programmed clock and of every extra clock after it. Each sample that finds it low adds one clock to the access.
- R7: `rdy_i` has no effect on fast-mode windows or on register or internal accesses.
- R8: An external access to a window with fast-mode bit 1 and a nonzero stretch field runs with the fast timing and sets `err_o`. `err_o` then stays 1 until reset. An access to a window that is set legally leaves `err_o` unchanged.
- R9: `rd_o` (for reads) or `wr_o` (for writes) is high on every clock of the access and never both. `done_o` is high for exactly the one clock right after the last strobe clock.
- R10: A configuration write with `cfg_sel`=0 loads the fast-mode bits from `cfg_wdata[3:0]` (bit i for window i). With `cfg_sel`=1 it loads the stretch fields, window i taking `cfg_wdata[2i+1:2i]`.
- R11: A request is taken only while `busy_o` is 0. `busy_o` is high on exactly the strobe clocks. A `req_valid` seen while busy is dropped, and it changes neither the running access nor what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0: fast-mode bits, 1: stretch fields |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Access request, one clock |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| rdy_i | input | 1 | Ready from slow devices, high when ready |
| busy_o | output | 1 | Access in progress |
| cs_o | output | 4 | Active-high chip selects, one per window |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Sticky illegal-setting flag |

## Verification
The assertions take for granted that configuration writes do not land in the middle of an access, and that `req_valid` is a plain level that the block samples only while idle. They also assume `rdy_i` is eventually raised, so the ready-hold property sees a bounded stretch. The stimulus changes settings only between accesses and holds ready low only for a fixed number of extra clocks. It keeps requests raised during busy clocks to a single dedicated scenario that drops them before the running access ends.

// File: rtl/csw_pkg.sv
package csw_pkg;

  localparam int CYC_W = 3;

  typedef enum logic [1:0] {
    AREA_REG = 2'd0,
    AREA_INT = 2'd1,
    AREA_EXT = 2'd2
  } area_e;

  // Slow-mode length from the stretch field; reads and writes share it.
  function automatic logic [CYC_W-1:0] slow_len(input logic [1:0] stretch);
    logic [CYC_W-1:0] len;
    case (stretch)
      2'b10:   len = CYC_W'(3);
      2'b11:   len = CYC_W'(4);
      default: len = CYC_W'(2);
    endcase
    return len;
  endfunction

  function automatic logic [CYC_W-1:0] read_len(input logic fast,
                                                input logic [1:0] stretch);
    return fast ? CYC_W'(1) : slow_len(stretch);
  endfunction

  function automatic logic [CYC_W-1:0] write_len(input logic fast,
                                                 input logic [1:0] stretch);
    return fast ? CYC_W'(2) : slow_len(stretch);
  endfunction

endpackage

// File: rtl/csw_cfg_regs.sv
module csw_cfg_regs
  import csw_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int EXPW = 2,
  localparam int DW  = NCS * EXPW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic                        cfg_sel,
  input  logic [DW-1:0]               cfg_wdata,
  output logic [NCS-1:0]              fast_o,
  output logic [NCS-1:0]              illegal_o,
  output logic [NCS-1:0][CYC_W-1:0]   rd_len_o,
  output logic [NCS-1:0][CYC_W-1:0]   wr_len_o
);

  logic [NCS-1:0] fast_q;
  logic [DW-1:0]  stretch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q    <= '0;
      stretch_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) fast_q    <= cfg_wdata[NCS-1:0];
      else          stretch_q <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_win
    logic [EXPW-1:0] st;
    assign st           = stretch_q[i*EXPW +: EXPW];
    assign fast_o[i]    = fast_q[i];
    assign illegal_o[i] = fast_q[i] && (st != '0);
    assign rd_len_o[i]  = read_len(fast_q[i], st);
    assign wr_len_o[i]  = write_len(fast_q[i], st);
  end

  // R1: settings come out of reset cleared
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fast_q == '0 && stretch_q == '0));

  // R10: settings move only on a configuration write
  a_r10_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) && !$past(rst) |-> ($stable(fast_q) && $stable(stretch_q)));

endmodule

// File: rtl/csw_addr_decode.sv
module csw_addr_decode
  import csw_pkg::*;
#(
  parameter int NCS = 4,
  localparam int IW = $clog2(NCS)
) (
  input  logic [2:0]    region_i,
  output area_e         area_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    idx_o = region_i[1:0];
    if (region_i[2])           area_o = AREA_EXT;
    else if (region_i[1])      area_o = AREA_INT;
    else if (region_i == 3'b0) area_o = AREA_REG;
    else                       area_o = AREA_INT;
  end

endmodule

// File: rtl/csw_sequencer.sv
module csw_sequencer
  import csw_pkg::*;
#(
  parameter int NCS     = 4,
  parameter int REG_CYC = 2,
  parameter int INT_CYC = 1,
  localparam int IW     = $clog2(NCS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  area_e                     area_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [NCS-1:0]            fast_i,
  input  logic [NCS-1:0]            illegal_i,
  input  logic [NCS-1:0][CYC_W-1:0] rd_len_i,
  input  logic [NCS-1:0][CYC_W-1:0] wr_len_i,
  input  logic                      rdy_i,
  output logic                      busy_o,
  output logic [NCS-1:0]            cs_o,
  output logic                      rd_o,
  output logic                      wr_o,
  output logic                      done_o,
  output logic                      err_o
);

  logic [CYC_W-1:0] len_q, cnt_q, len_sel;
  logic             ign_rdy_q, ign_sel, ext;
  logic             last;

  assign ext = (area_i == AREA_EXT);

  always_comb begin
    case (area_i)
      AREA_EXT: len_sel = req_write ? wr_len_i[idx_i] : rd_len_i[idx_i];
      AREA_REG: len_sel = CYC_W'(REG_CYC);
      default:  len_sel = CYC_W'(INT_CYC);
    endcase
    ign_sel = !ext || fast_i[idx_i];
  end

  assign last = (cnt_q >= len_q) && (ign_rdy_q || rdy_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      cs_o      <= '0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      len_q     <= '0;
      cnt_q     <= '0;
      ign_rdy_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (req_valid) begin
          busy_o    <= 1'b1;
          len_q     <= len_sel;
          cnt_q     <= CYC_W'(1);
          ign_rdy_q <= ign_sel;
          rd_o      <= !req_write;
          wr_o      <= req_write;
          cs_o      <= ext ? (NCS'(1) << idx_i) : '0;
          if (ext && illegal_i[idx_i]) err_o <= 1'b1;
        end
      end else if (last) begin
        busy_o <= 1'b0;
        rd_o   <= 1'b0;
        wr_o   <= 1'b0;
        cs_o   <= '0;
        done_o <= 1'b1;
      end else if (cnt_q < len_q) begin
        cnt_q <= cnt_q + CYC_W'(1);
      end
    end
  end

  // R9: never both strobes at once
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));

  // R9: completion follows the last strobe clock, strobes already low
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(rd_o || wr_o) && !rd_o && !wr_o && !busy_o));

  // R2: at most one chip select, and only with a strobe
  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o) && ((cs_o != '0) -> (rd_o || wr_o)));

  // R11: strobes and chip select keep their value through the access
  a_r11_no_midway_change: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last) |=> (busy_o && $stable(rd_o) && $stable(wr_o) && $stable(cs_o)));

  // R6: a low ready at the end of a slow external access holds it
  a_r6_ready_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !ign_rdy_q && cnt_q >= len_q && !rdy_i) |=> (busy_o && !done_o));

  // R8: the error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

endmodule

// File: rtl/csw_bus_seq.sv
module csw_bus_seq
  import csw_pkg::*;
#(
  parameter int NCS     = 4,
  parameter int EXPW    = 2,
  parameter int AW      = 16,
  parameter int REG_CYC = 2,
  parameter int INT_CYC = 1,
  localparam int DW     = NCS * EXPW,
  localparam int IW     = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  input  logic           rdy_i,
  output logic           busy_o,
  output logic [NCS-1:0] cs_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic           done_o,
  output logic           err_o
);

  logic [NCS-1:0]            fast, illegal;
  logic [NCS-1:0][CYC_W-1:0] rd_len, wr_len;
  area_e                     area;
  logic [IW-1:0]             idx;
  logic                      unused_low_addr;

  assign unused_low_addr = ^req_addr[AW-4:0];

  csw_cfg_regs #(.NCS(NCS), .EXPW(EXPW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .fast_o    (fast),
    .illegal_o (illegal),
    .rd_len_o  (rd_len),
    .wr_len_o  (wr_len)
  );

  csw_addr_decode #(.NCS(NCS)) u_dec (
    .region_i (req_addr[AW-1 -: 3]),
    .area_o   (area),
    .idx_o    (idx)
  );

  csw_sequencer #(.NCS(NCS), .REG_CYC(REG_CYC), .INT_CYC(INT_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .area_i    (area),
    .idx_i     (idx),
    .fast_i    (fast),
    .illegal_i (illegal),
    .rd_len_i  (rd_len),
    .wr_len_i  (wr_len),
    .rdy_i     (rdy_i),
    .busy_o    (busy_o),
    .cs_o      (cs_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

endmodule

// File: tb/tb_csw_bus_seq.sv
`timescale 1ns/1ps
module tb_csw_bus_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rdy_i = 1'b1;
  logic [15:0] req_addr = '0;
  logic        busy_o, rd_o, wr_o, done_o, err_o;
  logic [3:0]  cs_o;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  csw_bus_seq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .rdy_i(rdy_i),
    .busy_o(busy_o), .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one access; ready low for the whole access when use_rdy is 0,
  // otherwise low until extra clocks past exp_len have gone by.
  task automatic do_access(input logic [15:0] addr, input bit wr, input int exp_len,
                           input int extra, input bit use_rdy, input logic [3:0] exp_cs,
                           input string req);
    int c = 0;
    int bad = 0;
    @(negedge clk);
    req_addr = addr; req_write = wr; req_valid = 1'b1; rdy_i = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (!(rd_o || wr_o)) break;
      c++;
      if (rd_o == wr || wr_o != wr || cs_o != exp_cs || !busy_o || done_o) bad++;
      if (use_rdy && c >= exp_len + extra) rdy_i = 1'b1;
      @(negedge clk);
    end
    check(c == exp_len + extra, {req, " length"}, c, exp_len + extra);
    check(bad == 0, {req, " strobe/cs (R9 R2)"}, bad, 0);
    check(done_o && !busy_o, "R9 done after last strobe", done_o, 1);
    @(negedge clk);
    check(!done_o, "R9 done single clock", done_o, 0);
    rdy_i = 1'b1;
  endtask

  task automatic t_reset();
    check(!busy_o && cs_o == 0 && !rd_o && !wr_o && !done_o, "R1 outputs idle", cs_o, 0);
    check(!err_o, "R1 err clear", err_o, 0);
    do_access(16'h8000, 0, 2, 0, 1, 4'b0001, "R1 CS0 read default");
    do_access(16'hE010, 1, 2, 0, 1, 4'b1000, "R1 CS3 write default");
  endtask

  task automatic t_decode();
    do_access(16'h0040, 0, 2, 0, 1, 4'b0000, "R5 R2 reg read");
    do_access(16'h0100, 1, 2, 0, 1, 4'b0000, "R5 R2 reg write");
    do_access(16'h4000, 0, 1, 0, 1, 4'b0000, "R5 R2 internal 010");
    do_access(16'h7FFE, 1, 1, 0, 1, 4'b0000, "R5 R2 internal 011");
    do_access(16'hA123, 0, 2, 0, 1, 4'b0010, "R2 CS1 decode");
    do_access(16'hC000, 1, 2, 0, 1, 4'b0100, "R2 CS2 decode");
  endtask

  task automatic t_stretch();
    cfg_write(1, 8'b00_11_10_01); // R10: CS0=01 CS1=10 CS2=11 CS3=00
    do_access(16'h8000, 0, 2, 0, 1, 4'b0001, "R4 R10 CS0 st01 read");
    do_access(16'hA000, 0, 3, 0, 1, 4'b0010, "R4 R10 CS1 st10 read");
    do_access(16'hA000, 1, 3, 0, 1, 4'b0010, "R4 CS1 st10 write");
    do_access(16'hC000, 0, 4, 0, 1, 4'b0100, "R4 R10 CS2 st11 read");
    do_access(16'hC000, 1, 4, 0, 1, 4'b0100, "R4 CS2 st11 write");
    do_access(16'hE000, 1, 2, 0, 1, 4'b1000, "R4 CS3 st00 write");
    do_access(16'h0000, 0, 2, 0, 1, 4'b0000, "R5 reg unaffected by stretch");
  endtask

  task automatic t_fast();
    cfg_write(1, 8'b00_00_10_00); // CS1 keeps 10
    cfg_write(0, 8'b0000_0101);   // R10: CS0, CS2 fast
    do_access(16'h8000, 0, 1, 0, 1, 4'b0001, "R3 CS0 fast read");
    do_access(16'h8000, 1, 2, 0, 1, 4'b0001, "R3 CS0 fast write");
    do_access(16'hA000, 0, 3, 0, 1, 4'b0010, "R3 CS1 stays slow");
    do_access(16'hC000, 0, 1, 0, 0, 4'b0100, "R7 CS2 fast ignores ready");
    do_access(16'hC000, 1, 2, 0, 0, 4'b0100, "R7 CS2 fast write ignores ready");
    do_access(16'h0000, 0, 2, 0, 0, 4'b0000, "R7 reg ignores ready");
    do_access(16'h4000, 1, 1, 0, 0, 4'b0000, "R7 internal ignores ready");
    check(!err_o, "R8 legal settings no error", err_o, 0);
  endtask

  task automatic t_ready();
    do_access(16'hA000, 0, 3, 2, 1, 4'b0010, "R6 CS1 read +2");
    do_access(16'hA000, 1, 3, 1, 1, 4'b0010, "R6 CS1 write +1");
    do_access(16'hE000, 0, 2, 3, 1, 4'b1000, "R6 CS3 read +3");
  endtask

  task automatic t_busy();
    int nrd = 0, nwr = 0, nbusy = 0, ncs = 0;
    @(negedge clk);
    req_addr = 16'hA000; req_write = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) begin req_addr = 16'hE000; req_write = 1'b1; end
      if (k == 2) req_valid = 1'b0;
      if (rd_o) nrd++;
      if (wr_o) nwr++;
      if (busy_o) nbusy++;
      if (cs_o == 4'b0010) ncs++;
    end
    check(nrd == 3, "R11 running read untouched", nrd, 3);
    check(nwr == 0, "R11 busy request dropped", nwr, 0);
    check(nbusy == 3, "R11 busy on strobe clocks only", nbusy, 3);
    check(ncs == 3, "R11 cs kept", ncs, 3);
  endtask

  task automatic t_illegal();
    cfg_write(0, 8'b0000_1101);   // CS3 fast
    cfg_write(1, 8'b01_00_10_00); // CS3 stretch 01 -> illegal
    do_access(16'hA000, 0, 3, 0, 1, 4'b0010, "R8 legal CS1 access");
    check(!err_o, "R8 no error from other window", err_o, 0);
    do_access(16'hE000, 0, 1, 0, 0, 4'b1000, "R8 illegal read fast");
    check(err_o, "R8 error raised", err_o, 1);
    do_access(16'hE000, 1, 2, 0, 0, 4'b1000, "R8 illegal write fast");
    cfg_write(1, 8'b00_00_10_00);
    do_access(16'hE000, 0, 1, 0, 1, 4'b1000, "R8 fixed window");
    check(err_o, "R8 error sticky", err_o, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!err_o, "R1 reset clears error", err_o, 0);
    do_access(16'hE000, 0, 2, 0, 1, 4'b1000, "R1 settings cleared by reset");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_stretch();
    t_fast();
    t_ready();
    t_busy();
    t_illegal();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule